// File: doc/BRIEF.md
# Peripheral I/O Register Front-End

This block sits between a CPU data bus and a bank of peripheral control registers. The bus can issue byte, halfword and word accesses, but every register is 16 bits wide. A byte write is merged into the stored halfword. A word write is split into two halfword writes. Each halfword write then passes through the rules of the register it hits: a write mask, read-only status bits, ignored writes, write-one-to-clear behaviour, or a paired 32-bit update.

Reads are registered and return the value the CPU should see. Some registers cannot be read and return the open-bus value supplied from outside. A fixed set of unused holes reads as zero. The status and scanline registers take part of their read value from live inputs. The sound channel controls read as zero while the sound master switch is off.

The video, sound, DMA and timer engines are not part of this block. They see only the exported register contents, the 32-bit pair values with one-cycle update strobes, the sound master switch, and a pending-interrupt line.

Top module: `io_reg_frontend`

## Requirements
- R1: After reset, 0x000 reads 0x0080 and 0x088 reads 0x0200. The write-only affine entries at 0x020 and 0x026 (slot_q lanes 2 and 5) hold 0x0100. irq_pend and snd_on are 0.
- R2: A byte write (bus_size 0) places bus_wdata[7:0] in the upper byte when bus_addr[0] is 1 and in the lower byte otherwise. The other byte of the stored halfword is kept.
- R3: A word write (bus_size 2) to an ordinary register writes bus_wdata[15:0] at the 4-aligned address and bus_wdata[31:16] at that address plus 2. Each half obeys its own register's rules.
- R4: Pair k occupies 0x0B0+4k (low half) and 0x0B2+4k (high half). A halfword write to either half combines with the stored other half into the 32-bit pair_val lane k. A word write updates both halves. pair_upd[k] pulses in the cycle after the update, and at most one strobe is set at a time.
- R5: A write to the flag register 0x202 clears each flag bit that is 1 in the written value and leaves the other bits unchanged.
- R6: irq_set bits raise flags and win over a simultaneous clear. irq_pend is high when bit 0 of 0x208 is set and (0x200 AND 0x202) is nonzero. It reflects any write to 0x200, 0x202 or 0x208 in the cycle after that write.
- R7: Writes to 0x004 are masked with 0xFFF8. Its read value carries stat_bits in bits 2:0.
- R8: Writes to the scanline address 0x006 are ignored, and it always reads line_cnt zero-extended.
- R9: At 0x084 only bit 7 is writable. Bits 3:0 keep their value and all other bits read 0. snd_on equals bit 7.
- R10: The channel controls have these write masks: 0x060 0x007F, 0x062 0xFFFF, 0x064 0x47FF, 0x068 0xFFFF, 0x06C 0x47FF, 0x070 0x00E0, 0x072 0xE03F, 0x074 0x47FF, 0x078 0xFF3F, 0x07C 0x40FF, 0x080 0xFF77. They read 0 while snd_on is 0. The mixer control at 0x082 has mask 0x770F and is not gated.
- R11: Reads of the affine entries 0x020-0x026 and 0x030-0x036, the pairs, and any unmapped address return obus_val. Reads of 0x066, 0x06E, 0x076, 0x07A, 0x07E, 0x086, 0x08A, 0x136, 0x142, 0x15A and 0x206 return 0.
- R12: A read is returned on bus_rdata in the cycle after the request. A byte read gives the addressed lane in bits 7:0, a halfword read gives bits 15:0, and a word read gives {value at +2, value at the aligned address}. All unused upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, lane 0 aligned |
| bus_rdata | output | 32 | Registered read data |
| obus_val | input | 16 | Open-bus value for unreadable addresses |
| stat_bits | input | 3 | Live status bits for 0x004 |
| line_cnt | input | LINE_W | Live scanline count for 0x006 |
| irq_set | input | 16 | Peripheral flag set pulses |
| irq_pend | output | 1 | Pending interrupt |
| snd_on | output | 1 | Sound master switch |
| slot_q | output | NSLOT*16 | Stored register contents, slot index order |
| pair_val | output | NUM_PAIRS*32 | 32-bit pair values |
| pair_upd | output | NUM_PAIRS | One-cycle pair update strobes |

## Verification
Register state, pair values, pair strobes, snd_on and irq_pend change on the clock edge that accepts a write. The bench therefore checks them at the falling edge right after that edge. Read data is registered, so each read is driven at one falling edge and sampled at the next, one rising edge later. Flag pulses on irq_set follow the same one-edge rule. Inputs change only at falling edges, so no check depends on which process runs first at a rising edge.

// File: rtl/io_regs_pkg.sv
package io_regs_pkg;
   localparam int HW = 16;

   typedef enum logic [2:0] {SK_RW, SK_WO, SK_SND, SK_STAT, SK_MASTER, SK_IF} slot_kind_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam int NSLOT      = 27;
   localparam int IDX_STAT   = 1;
   localparam int IDX_MASTER = 22;
   localparam int IDX_IE     = 24;
   localparam int IDX_IF     = 25;
   localparam int IDX_IME    = 26;
   localparam logic [11:0] LINE_ADDR = 12'h006;

   typedef struct packed {
      logic [11:0] addr;
      logic [15:0] wmask;
      logic [15:0] rstv;
      slot_kind_e  kind;
   } slot_desc_t;

   // Descriptor of each stored halfword; slot index order is exported.
   function automatic slot_desc_t slot_desc(input int i);
      slot_desc_t d;
      int k;
      d.addr  = 12'h000;
      d.wmask = 16'hFFFF;
      d.rstv  = 16'h0000;
      d.kind  = SK_RW;
      k = i - 2;
      if (i >= 2 && i <= 9) begin
         d.addr = 12'(32'h020 + (k / 4) * 16 + (k % 4) * 2);
         d.rstv = (k % 4 == 0 || k % 4 == 3) ? 16'h0100 : 16'h0000;
         d.kind = SK_WO;
      end else begin
         case (i)
            0:  d.rstv = 16'h0080;
            1:  begin d.addr = 12'h004; d.wmask = 16'hFFF8; d.kind = SK_STAT; end
            10: begin d.addr = 12'h060; d.wmask = 16'h007F; d.kind = SK_SND; end
            11: begin d.addr = 12'h062; d.kind = SK_SND; end
            12: begin d.addr = 12'h064; d.wmask = 16'h47FF; d.kind = SK_SND; end
            13: begin d.addr = 12'h068; d.kind = SK_SND; end
            14: begin d.addr = 12'h06C; d.wmask = 16'h47FF; d.kind = SK_SND; end
            15: begin d.addr = 12'h070; d.wmask = 16'h00E0; d.kind = SK_SND; end
            16: begin d.addr = 12'h072; d.wmask = 16'hE03F; d.kind = SK_SND; end
            17: begin d.addr = 12'h074; d.wmask = 16'h47FF; d.kind = SK_SND; end
            18: begin d.addr = 12'h078; d.wmask = 16'hFF3F; d.kind = SK_SND; end
            19: begin d.addr = 12'h07C; d.wmask = 16'h40FF; d.kind = SK_SND; end
            20: begin d.addr = 12'h080; d.wmask = 16'hFF77; d.kind = SK_SND; end
            21: begin d.addr = 12'h082; d.wmask = 16'h770F; end
            22: begin d.addr = 12'h084; d.wmask = 16'h0080; d.kind = SK_MASTER; end
            23: begin d.addr = 12'h088; d.rstv = 16'h0200; end
            24: d.addr = 12'h200;
            25: begin d.addr = 12'h202; d.kind = SK_IF; end
            26: d.addr = 12'h208;
            default: ;
         endcase
      end
      return d;
   endfunction

   function automatic logic is_zero_hole(input logic [11:0] a);
      case (a)
         12'h066, 12'h06E, 12'h076, 12'h07A, 12'h07E, 12'h086,
         12'h08A, 12'h136, 12'h142, 12'h15A, 12'h206: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/io_lane_split.sv
module io_lane_split
   import io_regs_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              req,
   input  logic              we,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [15:0]       raw_lo,
   output logic [ADDR_W-1:0] a0,
   output logic [ADDR_W-1:0] a1,
   output logic              p0_v,
   output logic [15:0]       p0_d,
   output logic              p1_v,
   output logic [15:0]       p1_d
);
   logic is_word;
   assign is_word = (size == SZ_WORD);
   assign a0 = is_word ? {addr[ADDR_W-1:2], 2'b00} : {addr[ADDR_W-1:1], 1'b0};
   assign a1 = {a0[ADDR_W-1:2], 2'b10};

   always_comb begin
      p0_v = req && we;
      p1_v = req && we && is_word;
      p1_d = wdata[31:16];
      if (size == SZ_BYTE)
         p0_d = addr[0] ? {wdata[7:0], raw_lo[7:0]} : {raw_lo[15:8], wdata[7:0]};
      else
         p0_d = wdata[15:0];
   end
endmodule

// File: rtl/io_slot.sv
module io_slot
   import io_regs_pkg::*;
#(
   parameter int          ADDR_W    = 10,
   parameter int          SLOT_ADDR = 0,
   parameter logic [15:0] WMASK     = 16'hFFFF,
   parameter logic [15:0] RSTV      = 16'h0000,
   parameter slot_kind_e  KIND      = SK_RW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_v,
   input  logic [ADDR_W-1:0] p0_a,
   input  logic [15:0]       p0_d,
   input  logic              p1_v,
   input  logic [ADDR_W-1:0] p1_a,
   input  logic [15:0]       p1_d,
   input  logic [15:0]       irq_set,
   output logic [15:0]       q
);
   localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(SLOT_ADDR);
   logic hit0, hit1, hit;
   logic [15:0] val;
   assign hit0 = p0_v && (p0_a == MY_A);
   assign hit1 = p1_v && (p1_a == MY_A);
   assign hit  = hit0 || hit1;
   assign val  = hit0 ? p0_d : p1_d;

   generate
      if (KIND == SK_IF) begin : g_flag
         logic armed;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q     <= RSTV;
               armed <= 1'b0;
            end else begin
               q     <= (q & ~(hit ? (val & WMASK) : 16'h0)) | irq_set;
               armed <= 1'b1;
            end
         end
         AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && irq_set == 16'h0) |=> q == ($past(q) & ~$past(val)));   // R5
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> ((q & $past(irq_set)) == $past(irq_set)));           // R6
      end else if (KIND == SK_MASTER) begin : g_master
         logic unused_set;
         assign unused_set = ^irq_set;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RSTV;
            else if (hit) q <= (val & WMASK) | (q & 16'h000F);
         end
         AST_MASTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> (q[7] == $past(val[7]) && q[3:0] == $past(q[3:0])));   // R9
      end else begin : g_plain
         logic unused_set;
         assign unused_set = ^irq_set;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RSTV;
            else if (hit) q <= val & WMASK;
         end
      end
   endgenerate
endmodule

// File: rtl/io_pair.sv
module io_pair #(
   parameter int ADDR_W  = 10,
   parameter int LO_ADDR = 'h0B0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p0_v,
   input  logic [ADDR_W-1:0] p0_a,
   input  logic [15:0]       p0_d,
   input  logic              p1_v,
   input  logic [ADDR_W-1:0] p1_a,
   input  logic [15:0]       p1_d,
   output logic [31:0]       q,
   output logic              upd
);
   localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(LO_ADDR + 2);
   logic lo0, lo1, hi0, hi1, hit_lo, hit_hi;
   assign lo0 = p0_v && p0_a == LO_A;
   assign lo1 = p1_v && p1_a == LO_A;
   assign hi0 = p0_v && p0_a == HI_A;
   assign hi1 = p1_v && p1_a == HI_A;
   assign hit_lo = lo0 || lo1;
   assign hit_hi = hi0 || hi1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         upd <= 1'b0;
      end else begin
         if (hit_lo) q[15:0]  <= lo0 ? p0_d : p1_d;
         if (hit_hi) q[31:16] <= hi0 ? p0_d : p1_d;
         upd <= hit_lo || hit_hi;
      end
   end

   AST_PAIR_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_lo && !hit_hi) |=> q[31:16] == $past(q[31:16]));   // R4
endmodule

// File: rtl/io_hw_lookup.sv
module io_hw_lookup
   import io_regs_pkg::*;
#(
   parameter int ADDR_W         = 10,
   parameter int NUM_PAIRS      = 4,
   parameter int PAIR_BASE      = 'h0B0,
   parameter int LINE_W         = 8,
   parameter bit PAIR_READ_OPEN = 1'b1
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [NSLOT*16-1:0]     slot_q,
   input  logic [NUM_PAIRS*32-1:0] pair_q,
   input  logic [2:0]              stat_bits,
   input  logic [LINE_W-1:0]       line_cnt,
   input  logic                    snd_on,
   input  logic [15:0]             obus_val,
   output logic [15:0]             raw,
   output logic [15:0]             vis,
   output logic                    is_snd
);
   always_comb begin
      slot_desc_t d;
      logic [15:0] sq;
      raw    = '0;
      is_snd = 1'b0;
      vis    = is_zero_hole(12'(addr)) ? 16'h0 : obus_val;
      if (addr == ADDR_W'(LINE_ADDR)) vis = 16'(line_cnt);
      for (int i = 0; i < NSLOT; i++) begin
         d  = slot_desc(i);
         sq = slot_q[i*16 +: 16];
         if (addr == ADDR_W'(d.addr)) begin
            raw = sq;
            case (d.kind)
               SK_WO:   vis = obus_val;
               SK_STAT: vis = {sq[15:3], stat_bits};
               SK_SND:  begin vis = snd_on ? sq : 16'h0; is_snd = 1'b1; end
               default: vis = sq;
            endcase
         end
      end
      for (int p = 0; p < NUM_PAIRS; p++) begin
         if (addr == ADDR_W'(PAIR_BASE + 4 * p)) begin
            raw = pair_q[p*32 +: 16];
            vis = PAIR_READ_OPEN ? obus_val : pair_q[p*32 +: 16];
         end
         if (addr == ADDR_W'(PAIR_BASE + 4 * p + 2)) begin
            raw = pair_q[p*32+16 +: 16];
            vis = PAIR_READ_OPEN ? obus_val : pair_q[p*32+16 +: 16];
         end
      end
   end
endmodule

// File: rtl/io_reg_frontend.sv
module io_reg_frontend
   import io_regs_pkg::*;
#(
   parameter int ADDR_W         = 10,
   parameter int NUM_PAIRS      = 4,
   parameter int PAIR_BASE      = 'h0B0,
   parameter int LINE_W         = 8,
   parameter bit PAIR_READ_OPEN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [1:0]              bus_size,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [15:0]             obus_val,
   input  logic [2:0]              stat_bits,
   input  logic [LINE_W-1:0]       line_cnt,
   input  logic [15:0]             irq_set,
   output logic                    irq_pend,
   output logic                    snd_on,
   output logic [NSLOT*16-1:0]     slot_q,
   output logic [NUM_PAIRS*32-1:0] pair_val,
   output logic [NUM_PAIRS-1:0]    pair_upd
);
   localparam slot_desc_t D_IME  = slot_desc(IDX_IME);
   localparam slot_desc_t D_STAT = slot_desc(IDX_STAT);
   localparam logic [ADDR_W-1:0] IME_A  = ADDR_W'(D_IME.addr);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(D_STAT.addr);

   if (ADDR_W < 10 || ADDR_W > 12) begin : g_bad_aw
      $error("ADDR_W must be 10..12");
   end
   if (NUM_PAIRS < 1 || NUM_PAIRS > 8) begin : g_bad_np
      $error("NUM_PAIRS must be 1..8");
   end
   if (PAIR_BASE < 'h0A0 || PAIR_BASE + 4 * NUM_PAIRS > 'h100 || PAIR_BASE % 4 != 0) begin : g_bad_pb
      $error("pair window must be 4-aligned inside 0x0A0..0x0FF");
   end
   if (LINE_W < 1 || LINE_W > 16) begin : g_bad_lw
      $error("LINE_W must be 1..16");
   end

   logic [ADDR_W-1:0] a0, a1;
   logic        p0_v, p1_v;
   logic [15:0] p0_d, p1_d;
   logic [15:0] raw0, vis0, vis1, unused_raw1;
   logic        snd0, unused_snd1;

   io_lane_split #(.ADDR_W(ADDR_W)) u_split (
      .req(bus_req), .we(bus_we), .size(bus_size), .addr(bus_addr), .wdata(bus_wdata),
      .raw_lo(raw0), .a0(a0), .a1(a1), .p0_v(p0_v), .p0_d(p0_d), .p1_v(p1_v), .p1_d(p1_d)
   );

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam slot_desc_t D = slot_desc(g);
      io_slot #(
         .ADDR_W(ADDR_W), .SLOT_ADDR(int'(D.addr)), .WMASK(D.wmask), .RSTV(D.rstv), .KIND(D.kind)
      ) u_slot (
         .clk(clk), .rst_n(rst_n),
         .p0_v(p0_v), .p0_a(a0), .p0_d(p0_d),
         .p1_v(p1_v), .p1_a(a1), .p1_d(p1_d),
         .irq_set(irq_set), .q(slot_q[g*16 +: 16])
      );
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      io_pair #(.ADDR_W(ADDR_W), .LO_ADDR(PAIR_BASE + 4 * p)) u_pair (
         .clk(clk), .rst_n(rst_n),
         .p0_v(p0_v), .p0_a(a0), .p0_d(p0_d),
         .p1_v(p1_v), .p1_a(a1), .p1_d(p1_d),
         .q(pair_val[p*32 +: 32]), .upd(pair_upd[p])
      );
   end

   io_hw_lookup #(
      .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .PAIR_BASE(PAIR_BASE),
      .LINE_W(LINE_W), .PAIR_READ_OPEN(PAIR_READ_OPEN)
   ) u_look0 (
      .addr(a0), .slot_q(slot_q), .pair_q(pair_val), .stat_bits(stat_bits),
      .line_cnt(line_cnt), .snd_on(snd_on), .obus_val(obus_val),
      .raw(raw0), .vis(vis0), .is_snd(snd0)
   );
   io_hw_lookup #(
      .ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS), .PAIR_BASE(PAIR_BASE),
      .LINE_W(LINE_W), .PAIR_READ_OPEN(PAIR_READ_OPEN)
   ) u_look1 (
      .addr(a1), .slot_q(slot_q), .pair_q(pair_val), .stat_bits(stat_bits),
      .line_cnt(line_cnt), .snd_on(snd_on), .obus_val(obus_val),
      .raw(unused_raw1), .vis(vis1), .is_snd(unused_snd1)
   );

   assign snd_on   = slot_q[IDX_MASTER*16 + 7];
   assign irq_pend = slot_q[IDX_IME*16] &&
                     |(slot_q[IDX_IE*16 +: 16] & slot_q[IDX_IF*16 +: 16]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_req && !bus_we) begin
         case (bus_size)
            SZ_BYTE: bus_rdata <= {24'h0, bus_addr[0] ? vis0[15:8] : vis0[7:0]};
            SZ_WORD: bus_rdata <= {vis1, vis0};
            default: bus_rdata <= {16'h0, vis0};
         endcase
      end
   end

   AST_SND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_size == SZ_HALF && snd0 && !snd_on) |=> bus_rdata == 32'h0);  // R10
   AST_STAT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_size == SZ_HALF && a0 == STAT_A) |=> bus_rdata[2:0] == $past(stat_bits));  // R7
   AST_IME_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_size == SZ_HALF && a0 == IME_A && !bus_wdata[0]) |=> !irq_pend);  // R6
   AST_PAIR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pair_upd));  // R4
endmodule

// File: tb/tb_io_reg_frontend.sv
`timescale 1ns/1ps
module tb_io_reg_frontend;
   import io_regs_pkg::*;
   localparam int AW = 10, NP = 4, LW = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, bus_req, bus_we, irq_pend, snd_on;
   logic [1:0] bus_size;
   logic [AW-1:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [15:0] obus_val, irq_set;
   logic [2:0] stat_bits;
   logic [LW-1:0] line_cnt;
   logic [NSLOT*16-1:0] slot_q;
   logic [NP*32-1:0] pair_val;
   logic [NP-1:0] pair_upd;

   io_reg_frontend #(.ADDR_W(AW), .NUM_PAIRS(NP), .LINE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .obus_val(obus_val),
      .stat_bits(stat_bits), .line_cnt(line_cnt), .irq_set(irq_set), .irq_pend(irq_pend),
      .snd_on(snd_on), .slot_q(slot_q), .pair_val(pair_val), .pair_upd(pair_upd)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   logic [15:0] mdl [4];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sz, int a, logic [31:0] d, logic [15:0] set = 16'h0);
      @(negedge clk);
      bus_req = 1; bus_we = 1; bus_size = sz; bus_addr = AW'(a); bus_wdata = d; irq_set = set;
      @(negedge clk);
      bus_req = 0; bus_we = 0; irq_set = 0;
   endtask

   task automatic rd(logic [1:0] sz, int a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_size = sz; bus_addr = AW'(a);
      @(negedge clk);
      bus_req = 0;
      d = bus_rdata;
   endtask

   task automatic pulse(logic [15:0] set);
      @(negedge clk); irq_set = set;
      @(negedge clk); irq_set = 0;
   endtask

   // Bench model of the randomized subset: 0x000, 0x082, 0x088, 0x200
   function automatic int midx(int a);
      case (a & ~1)
         'h000: return 0;
         'h082: return 1;
         'h088: return 2;
         default: return 3;
      endcase
   endfunction
   function automatic logic [15:0] mmask(int a);
      return ((a & ~1) == 'h082) ? 16'h770F : 16'hFFFF;
   endfunction
   task automatic mwrite(logic [1:0] sz, int a, logic [31:0] d);
      logic [15:0] cur, nv;
      cur = mdl[midx(a)];
      if (sz == SZ_BYTE) nv = a[0] ? {d[7:0], cur[7:0]} : {cur[15:8], d[7:0]};
      else nv = d[15:0];
      mdl[midx(a)] = nv & mmask(a);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5EED1234));
      rst_n = 0; bus_req = 0; bus_we = 0; bus_size = 0; bus_addr = 0; bus_wdata = 0;
      obus_val = 16'hBEEF; stat_bits = 3'b101; line_cnt = 8'h5A; irq_set = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset values
      rd(SZ_HALF, 'h000, r); chk("R1 disp reset", r, 32'h0080);
      rd(SZ_HALF, 'h088, r); chk("R1 bias reset", r, 32'h0200);
      chk("R1 affine PA", 32'(slot_q[2*16 +: 16]), 32'h0100);
      chk("R1 affine PD", 32'(slot_q[5*16 +: 16]), 32'h0100);
      chk("R1 pend/snd", {30'h0, irq_pend, snd_on}, 32'h0);

      // R2 byte merge, R12 byte read
      wr(SZ_BYTE, 'h001, 32'h000000AB);
      rd(SZ_HALF, 'h000, r); chk("R2 upper lane", r, 32'hAB80);
      wr(SZ_BYTE, 'h000, 32'h00000012);
      rd(SZ_HALF, 'h000, r); chk("R2 lower lane", r, 32'hAB12);
      rd(SZ_BYTE, 'h001, r); chk("R12 byte read", r, 32'h000000AB);

      // R9 master, R3/R10 word write into sound group
      wr(SZ_HALF, 'h084, 32'h0000FFFF);
      rd(SZ_HALF, 'h084, r); chk("R9 master bits", r, 32'h0080);
      chk("R9 snd_on", {31'h0, snd_on}, 32'h1);
      wr(SZ_WORD, 'h080, 32'hFFFFFFFF);
      rd(SZ_WORD, 'h080, r); chk("R3 R10 R12 word split", r, 32'h770FFF77);
      wr(SZ_HALF, 'h060, 32'h0000FFFF);
      rd(SZ_HALF, 'h060, r); chk("R10 mask 0x060", r, 32'h007F);
      wr(SZ_BYTE, 'h084, 32'h00000000);
      chk("R9 snd off", {31'h0, snd_on}, 32'h0);
      rd(SZ_HALF, 'h080, r); chk("R10 gated read", r, 32'h0);
      rd(SZ_HALF, 'h082, r); chk("R10 mixer ungated", r, 32'h770F);

      // R7 status, R8 scanline
      wr(SZ_HALF, 'h004, 32'h0000FFFF);
      rd(SZ_HALF, 'h004, r); chk("R7 status read", r, 32'hFFFD);
      chk("R7 stored mask", 32'(slot_q[1*16 +: 16]), 32'hFFF8);
      wr(SZ_HALF, 'h006, 32'h0000FFFF);
      rd(SZ_HALF, 'h006, r); chk("R8 line ignored", r, 32'h005A);
      wr(SZ_WORD, 'h004, 32'h11112222);
      rd(SZ_WORD, 'h004, r); chk("R3 R7 R8 word", r, 32'h005A2225);

      // R11 open bus and zero holes
      rd(SZ_HALF, 'h020, r); chk("R11 write-only", r, 32'hBEEF);
      rd(SZ_HALF, 'h066, r); chk("R11 hole 066", r, 32'h0);
      rd(SZ_HALF, 'h206, r); chk("R11 hole 206", r, 32'h0);
      rd(SZ_HALF, 'h100, r); chk("R11 unmapped", r, 32'hBEEF);
      rd(SZ_HALF, 'h0B0, r); chk("R11 pair read", r, 32'hBEEF);

      // R4 pairs
      wr(SZ_HALF, 'h0B0, 32'h00001111);
      chk("R4 strobe lo", 32'(pair_upd), 32'h1);
      chk("R4 pair lo", pair_val[31:0], 32'h00001111);
      wr(SZ_HALF, 'h0B2, 32'h00002222);
      chk("R4 pair hi merge", pair_val[31:0], 32'h22221111);
      wr(SZ_WORD, 'h0B4, 32'hDEADBEEF);
      chk("R4 pair word", pair_val[63:32], 32'hDEADBEEF);
      chk("R4 strobe pair1", 32'(pair_upd), 32'h2);
      @(negedge clk);
      chk("R4 strobe ends", 32'(pair_upd), 32'h0);

      // R5 R6 interrupts
      wr(SZ_HALF, 'h200, 32'h00000005);
      pulse(16'h0007);
      rd(SZ_HALF, 'h202, r); chk("R6 set flags", r, 32'h0007);
      chk("R6 ime off", {31'h0, irq_pend}, 32'h0);
      wr(SZ_HALF, 'h208, 32'h00000001);
      chk("R6 pend on", {31'h0, irq_pend}, 32'h1);
      wr(SZ_HALF, 'h202, 32'h00000005);
      rd(SZ_HALF, 'h202, r); chk("R5 w1c", r, 32'h0002);
      chk("R6 pend after clear", {31'h0, irq_pend}, 32'h0);
      wr(SZ_HALF, 'h202, 32'h00000002, 16'h0002);
      rd(SZ_HALF, 'h202, r); chk("R6 set beats clear", r, 32'h0002);
      pulse(16'h0001);
      chk("R6 pend by set", {31'h0, irq_pend}, 32'h1);
      wr(SZ_HALF, 'h208, 32'h00000000);
      chk("R6 pend ime off", {31'h0, irq_pend}, 32'h0);

      // Randomized mix over the modelled subset (R2 R3 R12)
      begin
         int addrs [4] = '{'h000, 'h082, 'h088, 'h200};
         for (int i = 0; i < 4; i++) begin
            wr(SZ_HALF, addrs[i], 32'h0);
            mdl[i] = 16'h0;
         end
      end
      for (int it = 0; it < 300; it++) begin
         int sel, a;
         logic [31:0] d;
         sel = $urandom % 4;
         a = (sel == 0) ? 'h000 : (sel == 1) ? 'h082 : (sel == 2) ? 'h088 : 'h200;
         d = $urandom;
         case ($urandom % 4)
            0: begin a = a + ($urandom % 2); wr(SZ_BYTE, a, d); mwrite(SZ_BYTE, a, d); end
            1: begin wr(SZ_HALF, a, d); mwrite(SZ_HALF, a, d); end
            2: begin
               if (sel == 0 || sel == 2) begin
                  wr(SZ_WORD, a, d); mwrite(SZ_HALF, a, d);
               end else begin
                  wr(SZ_HALF, a, d); mwrite(SZ_HALF, a, d);
               end
            end
            default: begin
               rd(SZ_HALF, a, d);
               chk("R2 R3 random read", d, {16'h0, mdl[midx(a)]});
            end
         endcase
      end
      rd(SZ_WORD, 'h088, r); chk("R3 R11 word hole", r, {16'h0, mdl[2]});
      rd(SZ_WORD, 'h000, r); chk("R11 R12 word obus", r, {16'hBEEF, mdl[0]});

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule